// File: doc/BRIEF.md
# Residue Product Combination Stage

This stage serves one residue channel of a modular multiplier that keeps each field element as a pair: a high part K and a low part R, with the element equal to K·A + R. The field prime is chosen so that A² is congruent to 2. For that reason the product of two such pairs folds into two channel-sized sums. U collects the doubled high-by-high product plus the low-by-low product. V collects the two cross products. V is formed from a shared difference product, so only three modular multipliers are needed in place of four.

After U and V have been split into pairs again outside this block, the same stage runs in its second mode to rebuild the output pair. The new high part is the high part of U plus the low part of V. The new low part is the low part of U plus twice the high part of V. Every channel of the multiplier holds an identical copy of this stage with its own modulus. All arithmetic is reduced modulo that channel modulus. Both modes share one two-stage pipeline, and a result appears with a valid strobe two cycles after its input.

Top module: `residue_pair_combine`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and `out_p` and `out_q` are 0. An input accepted in the cycle that reset rises never produces a result.
- R2: Each cycle with `in_valid` high produces exactly one `out_valid` pulse, two clock cycles later. With no input, `out_valid` stays 0.
- R3: With `mode` = 0 (product mode), `out_p` = (2·Kx·Ky + Rx·Ry) mod MOD. Here Kx = `a_hi`, Rx = `a_lo`, Ky = `b_hi` and Ry = `b_lo`.
- R4: In product mode, `out_q` = (Kx·Ry + Ky·Rx) mod MOD. This holds for every ordering of Kx against Rx and of Ky against Ry, including wrapped differences.
- R5: With `mode` = 1 (recombine mode), `out_p` = (Ku + Rv) mod MOD. Here Ku = `a_hi`, Ru = `a_lo`, Kv = `b_hi` and Rv = `b_lo`.
- R6: In recombine mode, `out_q` = (2·Kv + Ru) mod MOD.
- R7: Whenever `out_valid` is 1, both `out_p` and `out_q` are below MOD, given operands below MOD.
- R8: `out_p` and `out_q` keep their last values in every cycle that does not deliver a result, whatever the operand and mode inputs do.
- R9: Inputs on consecutive cycles, in either mode and in any mix of modes, each give their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0 = product mode, 1 = recombine mode |
| a_hi | input | W | Kx in product mode, Ku in recombine mode |
| a_lo | input | W | Rx in product mode, Ru in recombine mode |
| b_hi | input | W | Ky in product mode, Kv in recombine mode |
| b_lo | input | W | Ry in product mode, Rv in recombine mode |
| out_valid | output | 1 | Result valid, two cycles after the input |
| out_p | output | W | U in product mode, Kz in recombine mode |
| out_q | output | W | V in product mode, Rz in recombine mode |

## Verification
The hardest case to reach is the cross term when both difference factors wrap below zero. The shared product then uses two residues near MOD. The final subtraction must also borrow, because the difference product exceeds the sum of the direct products. The stimulus reaches this case with operands at MOD−1 and with pairs whose low part exceeds the high part. The expected values come from the plain cross-product formula, so a wrong wrap in either the difference or the subtraction shows up.

Recombine sums that cross MOD twice come from operands at the top of the range. A product-mode input followed at once by a recombine input checks that the mode travels with its own data down the pipeline.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic {
    MODE_PROD   = 1'b0,
    MODE_RECOMB = 1'b1
  } rpc_mode_e;

  localparam int NUM_MUL = 3;
endpackage

// File: rtl/rpc_addmod.sv
module rpc_addmod #(
  parameter int W = 16,
  parameter longint unsigned MOD = 65521
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W:0] MODN = (W+1)'(MOD);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    if (sum >= MODN) y = W'(sum - MODN);
    else             y = W'(sum);
  end
endmodule

// File: rtl/rpc_submod.sv
module rpc_submod #(
  parameter int W = 16,
  parameter longint unsigned MOD = 65521
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W:0] MODN = (W+1)'(MOD);
  logic [W:0] wrapped;

  always_comb begin
    wrapped = {1'b0, a} + MODN - {1'b0, b};
    if (a >= b) y = a - b;
    else        y = W'(wrapped);
  end
endmodule

// File: rtl/rpc_mulmod.sv
module rpc_mulmod #(
  parameter int W = 16,
  parameter longint unsigned MOD = 65521
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] MODP = PW'(MOD);
  logic [PW-1:0] prod;
  logic [PW-1:0] rem;

  always_comb begin
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    rem  = prod % MODP;
    y    = W'(rem);
  end
endmodule

// File: rtl/residue_pair_combine.sv
module residue_pair_combine #(
  parameter int W = 16,
  parameter longint unsigned MOD = 65521
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         mode,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] a_lo,
  input  logic [W-1:0] b_hi,
  input  logic [W-1:0] b_lo,
  output logic         out_valid,
  output logic [W-1:0] out_p,
  output logic [W-1:0] out_q
);
  import rpc_pkg::*;

  // stage 1: differences, three concurrent products, recombine sums
  logic [W-1:0] diff_a, diff_b;
  logic [W-1:0] mul_x [NUM_MUL];
  logic [W-1:0] mul_y [NUM_MUL];
  logic [W-1:0] mul_r [NUM_MUL];
  logic [W-1:0] rc_hi, rc_dbl, rc_lo;

  rpc_submod #(.W(W), .MOD(MOD)) u_diff_a (.a(a_hi), .b(a_lo), .y(diff_a));
  rpc_submod #(.W(W), .MOD(MOD)) u_diff_b (.a(b_hi), .b(b_lo), .y(diff_b));

  // multiplier 0: Kx*Ky, 1: Rx*Ry, 2: (Kx-Rx)*(Ky-Ry)
  always_comb begin
    mul_x[0] = a_hi;   mul_y[0] = b_hi;
    mul_x[1] = a_lo;   mul_y[1] = b_lo;
    mul_x[2] = diff_a; mul_y[2] = diff_b;
  end

  for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
    rpc_mulmod #(.W(W), .MOD(MOD)) u_mul (
      .a(mul_x[g]), .b(mul_y[g]), .y(mul_r[g])
    );
  end

  rpc_addmod #(.W(W), .MOD(MOD)) u_rc_hi  (.a(a_hi),   .b(b_lo), .y(rc_hi));
  rpc_addmod #(.W(W), .MOD(MOD)) u_rc_dbl (.a(b_hi),   .b(b_hi), .y(rc_dbl));
  rpc_addmod #(.W(W), .MOD(MOD)) u_rc_lo  (.a(rc_dbl), .b(a_lo), .y(rc_lo));

  rpc_mode_e    s1_mode;
  logic         s1_valid;
  logic [W-1:0] s1_x, s1_y, s1_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_PROD;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_d     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode <= rpc_mode_e'(mode);
        s1_d    <= mul_r[2];
        if (rpc_mode_e'(mode) == MODE_RECOMB) begin
          s1_x <= rc_hi;
          s1_y <= rc_lo;
        end else begin
          s1_x <= mul_r[0];
          s1_y <= mul_r[1];
        end
      end
    end
  end

  // stage 2: U = 2*kk + rr, V = kk + rr - dd
  logic [W-1:0] two_kk, sum_u, sum_kr, sum_v;

  rpc_addmod #(.W(W), .MOD(MOD)) u_two_kk (.a(s1_x),   .b(s1_x), .y(two_kk));
  rpc_addmod #(.W(W), .MOD(MOD)) u_sum_u  (.a(two_kk), .b(s1_y), .y(sum_u));
  rpc_addmod #(.W(W), .MOD(MOD)) u_sum_kr (.a(s1_x),   .b(s1_y), .y(sum_kr));
  rpc_submod #(.W(W), .MOD(MOD)) u_sum_v  (.a(sum_kr), .b(s1_d), .y(sum_v));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_p     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        if (s1_mode == MODE_RECOMB) begin
          out_p <= s1_x;
          out_q <= s1_y;
        end else begin
          out_p <= sum_u;
          out_q <= sum_v;
        end
      end
    end
  end
endmodule

// File: rtl/residue_pair_combine_chk.sv
module residue_pair_combine_chk #(
  parameter int W = 16,
  parameter longint unsigned MOD = 65521
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         mode,
  input logic [W-1:0] a_hi,
  input logic [W-1:0] a_lo,
  input logic [W-1:0] b_hi,
  input logic [W-1:0] b_lo,
  input logic         out_valid,
  input logic [W-1:0] out_p,
  input logic [W-1:0] out_q
);
  localparam int XW = 2 * W + 2;
  localparam logic [XW-1:0] MODX = XW'(MOD);
  localparam logic [W-1:0]  MODW = W'(MOD);

  logic         v1, v2, m1, m2;
  logic [W-1:0] ah1, al1, bh1, bl1, ah2, al2, bh2, bl2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; m1 <= 1'b0; m2 <= 1'b0;
      ah1 <= '0; al1 <= '0; bh1 <= '0; bl1 <= '0;
      ah2 <= '0; al2 <= '0; bh2 <= '0; bl2 <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1;
      m1 <= mode;     m2 <= m1;
      ah1 <= a_hi; al1 <= a_lo; bh1 <= b_hi; bl1 <= b_lo;
      ah2 <= ah1;  al2 <= al1;  bh2 <= bh1;  bl2 <= bl1;
    end
  end

  logic [XW-1:0] xa, xb, xc, xd, e_u, e_v, e_kz, e_rz;
  always_comb begin
    xa   = XW'(ah2);
    xb   = XW'(al2);
    xc   = XW'(bh2);
    xd   = XW'(bl2);
    e_u  = (XW'(2) * xa * xc + xb * xd) % MODX;
    e_v  = (xa * xd + xc * xb) % MODX;
    e_kz = (xa + xd) % MODX;
    e_rz = (XW'(2) * xc + xb) % MODX;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  p_prod_u_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !m2) |-> (out_p == W'(e_u)));

  p_prod_v_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !m2) |-> (out_q == W'(e_v)));

  p_recomb_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && m2) |-> (out_p == W'(e_kz)));

  p_recomb_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && m2) |-> (out_q == W'(e_rz)));

  p_range_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_p < MODW) && (out_q < MODW)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> ($stable(out_p) && $stable(out_q)));
endmodule

bind residue_pair_combine residue_pair_combine_chk #(.W(W), .MOD(MOD)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
  .out_valid(out_valid), .out_p(out_p), .out_q(out_q)
);

// File: tb/sim_residue_pair_combine.sv
module sim_residue_pair_combine;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam longint unsigned MOD = 65521;
  localparam int NV = 10;

  // vector layout: {mode, a_hi, a_lo, b_hi, b_lo}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 16'd0,     16'd0,     16'd0,     16'd0},
    {1'b0, 16'd3,     16'd5,     16'd7,     16'd11},
    {1'b0, 16'd65520, 16'd65520, 16'd65520, 16'd65520},
    {1'b0, 16'd2,     16'd9,     16'd4,     16'd1},
    {1'b0, 16'd100,   16'd40000, 16'd65000, 16'd7},
    {1'b0, 16'd1,     16'd65520, 16'd0,     16'd65519},
    {1'b1, 16'd10,    16'd20,    16'd30,    16'd40},
    {1'b1, 16'd65520, 16'd65520, 16'd65520, 16'd65520},
    {1'b1, 16'd65000, 16'd5,     16'd33000, 16'd600},
    {1'b1, 16'd0,     16'd0,     16'd0,     16'd0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic         out_valid;
  logic [W-1:0] out_p, out_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  residue_pair_combine #(.W(W), .MOD(MOD)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .out_valid(out_valid), .out_p(out_p), .out_q(out_q)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint exp_p(input logic m, input longint ah, input longint al,
                                   input longint bh, input longint bl);
    if (m) return (ah + bl) % longint'(MOD);
    return (2 * ah * bh + al * bl) % longint'(MOD);
  endfunction

  function automatic longint exp_q(input logic m, input longint ah, input longint al,
                                   input longint bh, input longint bl);
    if (m) return (2 * bh + al) % longint'(MOD);
    return (ah * bl + bh * al) % longint'(MOD);
  endfunction

  task automatic drive(input logic [64:0] v);
    in_valid = 1'b1;
    mode = v[64];
    a_hi = v[63:48]; a_lo = v[47:32]; b_hi = v[31:16]; b_lo = v[15:0];
  endtask

  task automatic check_result(input logic [64:0] v);
    longint ep, eq;
    ep = exp_p(v[64], v[63:48], v[47:32], v[31:16], v[15:0]);
    eq = exp_q(v[64], v[63:48], v[47:32], v[31:16], v[15:0]);
    check("R2 out_valid", out_valid, 1);
    if (v[64]) begin
      check("R5 Kz", out_p, ep);
      check("R6 Rz", out_q, eq);
    end else begin
      check("R3 U", out_p, ep);
      check("R4 V", out_q, eq);
    end
    check("R7 range", (out_p < W'(MOD)) && (out_q < W'(MOD)), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", out_valid, 0);
    check("R1 reset p", out_p, 0);
    check("R1 reset q", out_q, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", out_valid, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 not early", out_valid, 0);
      @(negedge clk);
      check_result(VEC[i]);
    end

    // R8: hold with changing idle inputs
    begin
      logic [W-1:0] hp, hq;
      hp = out_p; hq = out_q;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        mode = k[0];
        a_hi = W'(k * 1234); a_lo = W'(k + 77); b_hi = W'(999 - k); b_lo = W'(k * 3);
        check("R2 idle no valid", out_valid, 0);
        check("R8 hold p", out_p, hp);
        check("R8 hold q", out_q, hq);
      end
    end

    // R9: back-to-back mixed modes
    @(negedge clk);
    drive(VEC[2]);
    @(negedge clk);
    drive(VEC[7]);
    @(negedge clk);
    drive(VEC[4]);
    check_result(VEC[2]);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(VEC[7]);
    @(negedge clk);
    check_result(VEC[4]);
    @(negedge clk);
    check("R9 single pulse", out_valid, 0);

    // R1: reset with pipeline loaded drops the input
    @(negedge clk);
    drive(VEC[1]);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset valid", out_valid, 0);
    check("R1 mid reset p", out_p, 0);
    check("R1 mid reset q", out_q, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dropped input", out_valid, 0);
    @(negedge clk);
    check("R1 dropped input late", out_valid, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule